// File: doc/BRIEF.md
# Compressed Load/Store Instruction Expander

This block turns a 16-bit compressed instruction into the matching 32-bit native instruction word, for the data-transfer and address-generation groups only. These groups cover register-offset and immediate-offset word, byte and halfword transfers, stack-pointer-relative transfers, program-counter or stack-pointer address add, stack-pointer adjust, push/pop and multiple-register transfer. Each group has a fixed native base word, chosen by one to three opcode bits. The operand fields of the compressed instruction are moved into that base word at new positions. Immediates are scaled by transfer size, or left unscaled when the base word's rotate field already applies the scaling.

A decode stage uses it in front of a native-only execution pipeline. The stage presents one instruction per cycle with a valid strobe. Any encoding outside the covered groups raises an unsupported flag and yields an all-zero word, so a neighbouring expander or a trap path can take it. An output register, present by default, gives a fixed latency of one clock.

Top module: `ldst_expander`

## Requirements
- R1: With bits[15:12]=0101 and bit 9=0, bits[11:10] select the base 0xE7800000 (0), 0xE7C00000 (1), 0xE7900000 (2) or 0xE7D00000 (3). Bits[2:0] go to [14:12], bits[5:3] to [18:16] and bits[8:6] to [2:0].
- R2: With bits[15:12]=0101 and bit 9=1, bits[11:10] select the base 0xE18000B0 (0), 0xE19000D0 (1), 0xE19000B0 (2) or 0xE19000F0 (3). The register fields are placed as in R1.
- R3: With bits[15:13]=011, bits[12:11] select the base 0xE5800000 (0), 0xE5900000 (1), 0xE5C00000 (2) or 0xE5D00000 (3). The registers are placed as in R1. The 5-bit offset in bits[10:6] is added times 4 when bit 12=0 and times 1 when bit 12=1.
- R4: With bits[15:12]=1000, bit 11 selects the base 0xE1D000B0 (1) or 0xE1C000B0 (0). The registers are placed as in R1. Twice the offset in bits[10:6] has its low four bits at [3:0] and its upper bits at [11:8].
- R5: With bits[15:12]=1001, bit 11 selects the base 0xE59D0000 (1) or 0xE58D0000 (0). Bits[10:8] go to [14:12], and bits[7:0] times 4 are added.
- R6: With bits[15:12]=1010, bit 11 selects the base 0xE28D0F00 (1) or 0xE28F0F00 (0). Bits[10:8] go to [14:12], and bits[7:0] go unshifted to [7:0].
- R7: With bits[15:8]=10110000, bit 7 selects the base 0xE24DDF00 (1) or 0xE28DDF00 (0), and bits[6:0] go unshifted to [6:0].
- R8: With bits[15:12]=1011 and bits[10:9]=10, the index {bit 11, bit 8} selects the base 0xE92D0000 (0), 0xE92D4000 (1), 0xE8BD0000 (2) or 0xE8BD8000 (3), and bits[7:0] are ORed in.
- R9: With bits[15:12]=1100, bit 11 selects the base 0xE8B00000 (1) or 0xE8A00000 (0). Bits[10:8] go to [18:16], and bits[7:0] are ORed in.
- R10: Every other encoding asserts the unsupported flag with an all-zero word. These are bits[15:12] of 0000 to 0100 or 1101 to 1111, and a 1011 form that matches neither R7 nor R8.
- R11: Out-valid, word and flag reflect the input presented one clock earlier. A clock edge with reset low forces out-valid low, the word to zero and the flag low.
- R12: An input cycle with in-valid low yields, one clock later, out-valid low, an all-zero word and a low flag, whatever the instruction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | INSN_W (16) | Compressed instruction |
| out_valid | output | 1 | Expanded word is valid |
| out_word | output | WORD_W (32) | Expanded native instruction |
| out_unsup | output | 1 | Encoding is outside the covered groups |

## Verification
On every cycle, the assertions check the following. Out-valid follows in-valid by one clock. Idle and unsupported outputs carry a zero word. Every unsupported top nibble raises the flag. Each expanded word carries the always-execute condition. The stack-relative and multiple-transfer register fields land at their target positions. Only the bench's scenarios can show that every base-word choice, offset scaling and halfword offset split is right, since these need a reference model. The bench sweeps all 65536 encodings with valid gaps between them and applies a reset mid-stream.

// File: rtl/ldst_exp_pkg.sv
package ldst_exp_pkg;

   localparam int NATIVE_W = 32;
   localparam int SHORT_W  = 16;
   localparam int REG_W    = 3;

   typedef enum logic [3:0] {
      GRP_NONE      = 4'd0,
      GRP_REGOFF_WB = 4'd1,
      GRP_REGOFF_HS = 4'd2,
      GRP_IMM_WB    = 4'd3,
      GRP_IMM_H     = 4'd4,
      GRP_SPREL     = 4'd5,
      GRP_ADDR      = 4'd6,
      GRP_SPADJ     = 4'd7,
      GRP_STACK     = 4'd8,
      GRP_MULTI     = 4'd9
   } grp_e;

   typedef logic [NATIVE_W-1:0] word_t;

   localparam word_t RO_WB_BASE [4] = '{32'hE780_0000, 32'hE7C0_0000,
                                        32'hE790_0000, 32'hE7D0_0000};
   localparam word_t RO_HS_BASE [4] = '{32'hE180_00B0, 32'hE190_00D0,
                                        32'hE190_00B0, 32'hE190_00F0};
   localparam word_t IM_WB_BASE [4] = '{32'hE580_0000, 32'hE590_0000,
                                        32'hE5C0_0000, 32'hE5D0_0000};
   localparam word_t STACK_BASE [4] = '{32'hE92D_0000, 32'hE92D_4000,
                                        32'hE8BD_0000, 32'hE8BD_8000};

   localparam word_t IM_H_LD   = 32'hE1D0_00B0;
   localparam word_t IM_H_ST   = 32'hE1C0_00B0;
   localparam word_t SPREL_LD  = 32'hE59D_0000;
   localparam word_t SPREL_ST  = 32'hE58D_0000;
   localparam word_t ADDR_SP   = 32'hE28D_0F00;
   localparam word_t ADDR_PC   = 32'hE28F_0F00;
   localparam word_t SPADJ_SUB = 32'hE24D_DF00;
   localparam word_t SPADJ_ADD = 32'hE28D_DF00;
   localparam word_t MULTI_LD  = 32'hE8B0_0000;
   localparam word_t MULTI_ST  = 32'hE8A0_0000;

endpackage

// File: rtl/ldst_exp_classify.sv
module ldst_exp_classify
   import ldst_exp_pkg::*;
(
   input  logic [7:0] insn_hi,
   output grp_e       grp
);
   logic [3:0] major;
   logic [3:0] minor;

   assign major = insn_hi[7:4];
   assign minor = insn_hi[3:0];

   always_comb begin
      grp = GRP_NONE;
      unique case (major)
         4'b0101: grp = minor[1] ? GRP_REGOFF_HS : GRP_REGOFF_WB;
         4'b0110,
         4'b0111: grp = GRP_IMM_WB;
         4'b1000: grp = GRP_IMM_H;
         4'b1001: grp = GRP_SPREL;
         4'b1010: grp = GRP_ADDR;
         4'b1011: begin
            if (minor == 4'b0000)
               grp = GRP_SPADJ;
            else if (minor[2:1] == 2'b10)
               grp = GRP_STACK;
            else
               grp = GRP_NONE;
         end
         4'b1100: grp = GRP_MULTI;
         default: grp = GRP_NONE;
      endcase
   end
endmodule

// File: rtl/ldst_exp_assemble.sv
module ldst_exp_assemble
   import ldst_exp_pkg::*;
(
   input  grp_e        grp,
   input  logic [12:0] insn_lo,
   output word_t       word,
   output logic        unsup
);
   word_t rd_lo, rb_lo, ro_lo, rd_hi, rb_hi;
   word_t off5_w, off5_b, off5_h, off8_x4, off8_x1, off7_x1;

   assign rd_lo   = word_t'(insn_lo[REG_W-1:0]) << 12;
   assign rb_lo   = word_t'(insn_lo[2*REG_W-1:REG_W]) << 16;
   assign ro_lo   = word_t'(insn_lo[3*REG_W-1:2*REG_W]);
   assign rd_hi   = word_t'(insn_lo[10:8]) << 12;
   assign rb_hi   = word_t'(insn_lo[10:8]) << 16;
   assign off5_w  = word_t'(insn_lo[10:6]) << 2;
   assign off5_b  = word_t'(insn_lo[10:6]);
   assign off5_h  = (word_t'(insn_lo[8:6]) << 1) | (word_t'(insn_lo[10:9]) << 8);
   assign off8_x4 = word_t'(insn_lo[7:0]) << 2;
   assign off8_x1 = word_t'(insn_lo[7:0]);
   assign off7_x1 = word_t'(insn_lo[6:0]);

   always_comb begin
      word  = '0;
      unsup = 1'b0;
      unique case (grp)
         GRP_REGOFF_WB: word = RO_WB_BASE[insn_lo[11:10]] | rd_lo | rb_lo | ro_lo;
         GRP_REGOFF_HS: word = RO_HS_BASE[insn_lo[11:10]] | rd_lo | rb_lo | ro_lo;
         GRP_IMM_WB:    word = IM_WB_BASE[insn_lo[12:11]] | rd_lo | rb_lo
                               | (insn_lo[12] ? off5_b : off5_w);
         GRP_IMM_H:     word = (insn_lo[11] ? IM_H_LD : IM_H_ST) | rd_lo | rb_lo | off5_h;
         GRP_SPREL:     word = (insn_lo[11] ? SPREL_LD : SPREL_ST) | rd_hi | off8_x4;
         GRP_ADDR:      word = (insn_lo[11] ? ADDR_SP : ADDR_PC) | rd_hi | off8_x1;
         GRP_SPADJ:     word = (insn_lo[7] ? SPADJ_SUB : SPADJ_ADD) | off7_x1;
         GRP_STACK:     word = STACK_BASE[{insn_lo[11], insn_lo[8]}] | off8_x1;
         GRP_MULTI:     word = (insn_lo[11] ? MULTI_LD : MULTI_ST) | rb_hi | off8_x1;
         default: begin
            word  = '0;
            unsup = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/ldst_exp_stage.sv
module ldst_exp_stage #(
   parameter int WORD_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [WORD_W-1:0] d_word,
   input  logic              d_unsup,
   output logic              q_valid,
   output logic [WORD_W-1:0] q_word,
   output logic              q_unsup
);
   logic [WORD_W-1:0] gated_word;
   logic              gated_unsup;

   assign gated_word  = d_valid ? d_word : '0;
   assign gated_unsup = d_valid & d_unsup;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q_word  <= '0;
            q_unsup <= 1'b0;
         end else begin
            q_valid <= d_valid;
            q_word  <= gated_word;
            q_unsup <= gated_unsup;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_valid = d_valid;
      assign q_word  = gated_word;
      assign q_unsup = gated_unsup;
   end
endmodule

// File: rtl/ldst_expander.sv
module ldst_expander #(
   parameter int INSN_W  = 16,
   parameter int WORD_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_insn,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic              out_unsup
);
   import ldst_exp_pkg::*;

   if (INSN_W != SHORT_W) begin : g_bad_insn_w
      $error("ldst_expander: INSN_W must be %0d", SHORT_W);
   end
   if (WORD_W != NATIVE_W) begin : g_bad_word_w
      $error("ldst_expander: WORD_W must be %0d", NATIVE_W);
   end

   grp_e  grp;
   word_t comb_word;
   logic  comb_unsup;

   ldst_exp_classify u_classify (
      .insn_hi (in_insn[15:8]),
      .grp     (grp)
   );

   ldst_exp_assemble u_assemble (
      .grp     (grp),
      .insn_lo (in_insn[12:0]),
      .word    (comb_word),
      .unsup   (comb_unsup)
   );

   ldst_exp_stage #(
      .WORD_W  (WORD_W),
      .REG_OUT (REG_OUT)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_word  (comb_word),
      .d_unsup (comb_unsup),
      .q_valid (out_valid),
      .q_word  (out_word),
      .q_unsup (out_unsup)
   );
endmodule

// File: rtl/ldst_expander_chk.sv
module ldst_expander_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [3:0]  op_nib,
   input logic [2:0]  fld_hi,
   input logic        out_valid,
   input logic [31:0] out_word,
   input logic        out_unsup
);
   logic bad_major;
   assign bad_major = (op_nib <= 4'd4) || (op_nib >= 4'd13);

   AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_unsup |-> out_word == 32'd0);                                   // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_word == 32'd0 && !out_unsup));                  // R12
   AST_ALWAYS_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_unsup) |-> out_word[31:28] == 4'hE);             // R1

   if (REG_OUT) begin : g_seq
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);                                         // R11
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);                                       // R12
      AST_UNSUP_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && bad_major) |=> out_unsup);                          // R10
      AST_SPREL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_nib == 4'd9) |=>
            (out_word[14:12] == $past(fld_hi) && out_word[19:16] == 4'hD)); // R5
      AST_MULTI_BASE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_nib == 4'd12) |=> out_word[18:16] == $past(fld_hi)); // R9
   end else begin : g_comb
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> out_valid);                                         // R11
      AST_UNSUP_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && bad_major) |-> out_unsup);                          // R10
      AST_SPREL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_nib == 4'd9) |-> out_word[14:12] == fld_hi);     // R5
      AST_MULTI_BASE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_nib == 4'd12) |-> out_word[18:16] == fld_hi);    // R9
   end
endmodule

bind ldst_expander ldst_expander_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_nib    (in_insn[15:12]),
   .fld_hi    (in_insn[10:8]),
   .out_valid (out_valid),
   .out_word  (out_word),
   .out_unsup (out_unsup)
);

// File: tb/ldst_expander_test.sv
module ldst_expander_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_insn = 16'h0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_unsup;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ldst_expander uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .out_valid(out_valid), .out_word(out_word), .out_unsup(out_unsup)
   );

   typedef struct { logic v; logic [31:0] w; logic u; string req; } exp_t;
   exp_t pending[$];

   function automatic exp_t model(input logic [15:0] t, input logic v);
      exp_t e;
      longint w = 0;
      int rd = int'(t[2:0]);
      int rb = int'(t[5:3]);
      int ro = int'(t[8:6]);
      int hi = int'(t[10:8]);
      int o5 = int'(t[10:6]);
      e.v = v; e.u = 1'b0; e.req = "R10";
      if (!v) begin
         e.w = 0; e.req = "R12"; return e;
      end
      case (t[15:12])
         4'd5: if (!t[9]) begin
            case (t[11:10]) 0: w = 'hE7800000; 1: w = 'hE7C00000;
                            2: w = 'hE7900000; default: w = 'hE7D00000; endcase
            w = w + rd * 4096 + rb * 65536 + ro; e.req = "R1";
         end else begin
            case (t[11:10]) 0: w = 'hE18000B0; 1: w = 'hE19000D0;
                            2: w = 'hE19000B0; default: w = 'hE19000F0; endcase
            w = w + rd * 4096 + rb * 65536 + ro; e.req = "R2";
         end
         4'd6, 4'd7: begin
            case (t[12:11]) 0: w = 'hE5800000; 1: w = 'hE5900000;
                            2: w = 'hE5C00000; default: w = 'hE5D00000; endcase
            w = w + rd * 4096 + rb * 65536 + (t[12] ? o5 : o5 * 4); e.req = "R3";
         end
         4'd8: begin
            int off = o5 * 2;
            w = (t[11] ? 'hE1D000B0 : 'hE1C000B0) + rd * 4096 + rb * 65536
                + (off % 16) + (off / 16) * 256;
            e.req = "R4";
         end
         4'd9: begin
            w = (t[11] ? 'hE59D0000 : 'hE58D0000) + hi * 4096 + int'(t[7:0]) * 4; e.req = "R5";
         end
         4'd10: begin
            w = (t[11] ? 'hE28D0F00 : 'hE28F0F00) + hi * 4096 + int'(t[7:0]); e.req = "R6";
         end
         4'd11: begin
            if (t[11:8] == 4'd0) begin
               w = (t[7] ? 'hE24DDF00 : 'hE28DDF00) + int'(t[6:0]); e.req = "R7";
            end else if (t[10:9] == 2'b10) begin
               case ({t[11], t[8]}) 0: w = 'hE92D0000; 1: w = 'hE92D4000;
                                    2: w = 'hE8BD0000; default: w = 'hE8BD8000; endcase
               w = w + int'(t[7:0]); e.req = "R8";
            end else begin
               e.u = 1'b1; e.req = "R10";
            end
         end
         4'd12: begin
            w = (t[11] ? 'hE8B00000 : 'hE8A00000) + hi * 65536 + int'(t[7:0]); e.req = "R9";
         end
         default: begin e.u = 1'b1; e.req = "R10"; end
      endcase
      e.w = w[31:0];
      return e;
   endfunction

   task automatic compare(input exp_t e);
      checks++;
      if (out_valid !== e.v || out_word !== e.w || out_unsup !== e.u) begin
         errors++;
         $display("FAIL %s: got v=%0b w=%h u=%0b expected v=%0b w=%h u=%0b",
                  e.req, out_valid, out_word, out_unsup, e.v, e.w, e.u);
      end
   endtask

   // drive at negedge, compare the previous cycle's expectation at the next negedge
   task automatic step(input logic [15:0] t, input logic v);
      in_insn  = t;
      in_valid = v;
      pending.push_back(model(t, v));
      @(posedge clk);
      @(negedge clk);
      compare(pending.pop_front());
   endtask

   task automatic reset_step(input logic [15:0] t);
      exp_t e;
      rst_n = 1'b0; in_insn = t; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      e.v = 1'b0; e.w = 0; e.u = 1'b0; e.req = "R11";
      compare(e);
      rst_n = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      reset_step(16'h5A5A);                 // R11 reset state
      reset_step(16'hF000);                 // R11 reset hides unsupported
      // directed corners per group
      step(16'h5000, 1'b1);                 // R1 all-zero fields
      step(16'h5DFF, 1'b1);                 // R1 load byte, all fields set
      step(16'h5E3F, 1'b1);                 // R2 load signed half
      step(16'h67C0, 1'b1);                 // R3 word offset x4
      step(16'h77C0, 1'b1);                 // R3 byte offset x1
      step(16'h8FC0, 1'b1);                 // R4 split offset max
      step(16'h9FFF, 1'b1);                 // R5
      step(16'hA0FF, 1'b1);                 // R6 PC base
      step(16'hB0FF, 1'b1);                 // R7 subtract
      step(16'hB57F, 1'b1);                 // R7 lookalike: 1011 0101 -> R8
      step(16'hBD80, 1'b1);                 // R8 pop with pc
      step(16'hBE00, 1'b1);                 // R10 1011 other form
      step(16'hCFFF, 1'b1);                 // R9
      step(16'h4123, 1'b1);                 // R10
      step(16'hD000, 1'b1);                 // R10
      step(16'h9FFF, 1'b0);                 // R12 invalid ignored
      step(16'hF123, 1'b0);                 // R12 unsupported while idle
      // full sweep with periodic idle cycles carrying live bits
      for (int i = 0; i < 65536; i++) begin
         step(16'(i), 1'b1);
         if (i % 97 == 0) step(16'(i) ^ 16'h9A5C, 1'b0);   // R12
         if (i == 30000) reset_step(16'(i));               // R11 mid-stream
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule